// File: doc/BRIEF.md
# Treelet Queue Binding Scheduler

This block decides which ray queue each processor of a parallel ray tracer works on. The scene hierarchy is cut into treelets, each small enough to sit in a processor's cache, and every treelet owns one queue of waiting rays. The index of that queue comes from the node index of the node where a ray enters the treelet. Moving a processor to a different treelet means fetching new scene data, so the scheduler keeps each processor on its queue for as long as possible. A processor is moved only when it reports that its input queue has run dry. The scheduler moves at most one processor per clock, and a move takes effect one cycle after it is requested.

Two policies can be selected at run time. The fullest-queue policy sends a drained processor to whichever queue holds the most rays, so many processors may end up on one queue. The need-based policy treats every queue as asking for a number of processors, set by its ray count and a per-processor quota. The drained processor goes to the queue whose outstanding request is largest. When no queue qualifies, the processor is parked idle, which tells the launcher that its share of the batch is done.

A forwarding lookup runs beside the binding table. When a ray leaves one treelet for another, the lookup reports whether the target queue is already being served and by which processor. The ray can then be handed over directly instead of being written back to memory.

Top module: `treelet_binder`

## Requirements
- R1: After reset every processor is idle (`bind_valid` all zero, `bind_q` all zero) and the lookup reports no hit.
- R2: A processor whose `proc_empty` bit is low at a clock edge keeps its binding (valid flag and queue index) unchanged across that edge.
- R3: At most one processor is rebound per clock. Among processors with `proc_empty` high, the one chosen is the first found searching upward, with wrap-around, from the processor after the one last rebound. After reset the search starts at processor 0.
- R4: With `policy` = 0 (fullest queue), the rebound processor takes the queue with the largest `q_count`. A tie goes to the lowest queue index. Only queues with a count above zero qualify.
- R5: With `policy` = 1 (need-based), a queue's request is ceil(count / QUOTA), with QUOTA = 4 by default. Its need is the request minus the number of valid processors bound to it, not counting the processor being rebound. The rebound processor takes the queue with the largest positive need, and a tie goes to the lowest index.
- R6: If no queue qualifies under the active policy, the rebound processor becomes idle: its valid flag is cleared and its queue index is set to 0.
- R7: `lookup_hit` is high in the same cycle exactly when some valid processor is bound to `lookup_q`. `lookup_proc` then gives the lowest-numbered such processor, and it is 0 on a miss.
- R8: A rebind decision uses the inputs sampled at one clock edge and appears on `bind_valid`/`bind_q` immediately after that edge.
- R9: Under the fullest-queue policy, several processors may hold the same queue at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 1 | 0 = fullest queue, 1 = need-based |
| q_count | input | NUM_Q*CNT_W | Ray count per queue; queue q in bits [q*CNT_W +: CNT_W] |
| proc_empty | input | NUM_PROC | Bit p high: processor p's input queue is empty |
| lookup_q | input | QW | Target queue for the forwarding lookup |
| bind_valid | output | NUM_PROC | Bit p high: processor p is bound to a queue |
| bind_q | output | NUM_PROC*QW | Queue of processor p in bits [p*QW +: QW] |
| lookup_hit | output | 1 | Target queue is served by some processor |
| lookup_proc | output | PW | Lowest processor serving the target queue |

## Verification
The hardest case to reach is a need-based decision in which queues already hold more processors than they ask for. The need then goes to zero for one queue while two others tie. To reach it, the bench first uses the fullest-queue policy to pile four processors onto a single queue. It then switches policy and drains six further processors in turn, so each grant lowers the need of the queue it went to and moves the next winner. A long pseudo-random phase follows that toggles the policy, the counts and the empty flags. A behavioural model is compared against the design on every clock throughout.

// File: rtl/treelet_bind_pkg.sv
package treelet_bind_pkg;
    typedef enum logic {
        POL_FULLEST  = 1'b0,
        POL_NEEDBASE = 1'b1
    } policy_e;
endpackage

// File: rtl/tqb_argmax.sv
// Largest eligible value; ties resolve to the lowest index.
module tqb_argmax #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [N*W-1:0] vals,
    input  logic [N-1:0]   elig,
    output logic           found,
    output logic [IW-1:0]  idx
);
    logic [W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || vals[i*W +: W] > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = vals[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/tqb_need.sv
// Per-queue outstanding processor request for the need-based policy.
module tqb_need #(
    parameter int NUM_Q    = 8,
    parameter int NUM_PROC = 16,
    parameter int CNT_W    = 8,
    parameter int QUOTA    = 4,
    parameter int QW       = 3,
    parameter int PW       = 4,
    parameter int NW       = 9
) (
    input  logic [NUM_Q*CNT_W-1:0]  counts,
    input  logic [NUM_PROC-1:0]     bv,
    input  logic [NUM_PROC*QW-1:0]  bq,
    input  logic                    self_valid,
    input  logic [QW-1:0]           self_q,
    output logic [NUM_Q*NW-1:0]     need,
    output logic [NUM_Q-1:0]        elig
);
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic [PW:0]   bnd;
        logic [NW-1:0] rq;
        logic [NW-1:0] nd;

        always_comb begin
            bnd = '0;
            for (int p = 0; p < NUM_PROC; p++) begin
                if (bv[p] && bq[p*QW +: QW] == QW'(q)) begin
                    bnd = bnd + 1'b1;
                end
            end
            if (self_valid && self_q == QW'(q)) begin
                bnd = bnd - 1'b1;
            end
            rq = (NW'(counts[q*CNT_W +: CNT_W]) + NW'(QUOTA - 1)) / NW'(QUOTA);
            nd = (rq > NW'(bnd)) ? (rq - NW'(bnd)) : '0;
        end

        assign need[q*NW +: NW] = nd;
        assign elig[q]          = (nd != '0);
    end
endmodule

// File: rtl/tqb_pick.sv
// Rotating-priority choice of the next processor to rebind.
module tqb_pick #(
    parameter int NUM_PROC = 16,
    parameter int PW       = 4
) (
    input  logic [NUM_PROC-1:0] req,
    input  logic [PW-1:0]       start,
    output logic                found,
    output logic [PW-1:0]       idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_PROC; i++) begin
            int j;
            j = (int'(start) + i) % NUM_PROC;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = PW'(j);
            end
        end
    end
endmodule

// File: rtl/tqb_lookup.sv
// Forwarding lookup: lowest processor bound to the key queue.
module tqb_lookup #(
    parameter int NUM_PROC = 16,
    parameter int QW       = 3,
    parameter int PW       = 4
) (
    input  logic [NUM_PROC-1:0]    bv,
    input  logic [NUM_PROC*QW-1:0] bq,
    input  logic [QW-1:0]          key,
    output logic                   hit,
    output logic [PW-1:0]          proc
);
    always_comb begin
        hit  = 1'b0;
        proc = '0;
        for (int p = 0; p < NUM_PROC; p++) begin
            if (!hit && bv[p] && bq[p*QW +: QW] == key) begin
                hit  = 1'b1;
                proc = PW'(p);
            end
        end
    end
endmodule

// File: rtl/treelet_binder.sv
module treelet_binder #(
    parameter int NUM_PROC = 16,
    parameter int NUM_Q    = 8,
    parameter int CNT_W    = 8,
    parameter int QUOTA    = 4,
    localparam int QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int PW      = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    policy,
    input  logic [NUM_Q*CNT_W-1:0]  q_count,
    input  logic [NUM_PROC-1:0]     proc_empty,
    input  logic [QW-1:0]           lookup_q,
    output logic [NUM_PROC-1:0]     bind_valid,
    output logic [NUM_PROC*QW-1:0]  bind_q,
    output logic                    lookup_hit,
    output logic [PW-1:0]           lookup_proc
);
    import treelet_bind_pkg::*;

    localparam int NW = CNT_W + 1;

    typedef struct packed {
        logic [NUM_PROC-1:0]          valid;
        logic [NUM_PROC-1:0][QW-1:0]  qsel;
        logic [PW-1:0]                ptr;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_PROC*QW-1:0] qsel_flat;
    logic                   pick_found;
    logic [PW-1:0]          pick_idx;
    logic                   self_valid;
    logic [QW-1:0]          self_q;
    logic [NUM_Q*NW-1:0]    need;
    logic [NUM_Q-1:0]       need_elig;
    logic [NUM_Q-1:0]       cnt_elig;
    logic                   full_found, need_found;
    logic [QW-1:0]          full_idx, need_idx;
    policy_e                pol;

    assign pol        = policy_e'(policy);
    assign qsel_flat  = state_q.qsel;
    assign self_valid = state_q.valid[pick_idx];
    assign self_q     = state_q.qsel[pick_idx];

    for (genvar q = 0; q < NUM_Q; q++) begin : g_elig
        assign cnt_elig[q] = (q_count[q*CNT_W +: CNT_W] != '0);
    end

    tqb_pick #(.NUM_PROC(NUM_PROC), .PW(PW)) u_pick (
        .req   (proc_empty),
        .start (state_q.ptr),
        .found (pick_found),
        .idx   (pick_idx)
    );

    tqb_need #(
        .NUM_Q(NUM_Q), .NUM_PROC(NUM_PROC), .CNT_W(CNT_W), .QUOTA(QUOTA),
        .QW(QW), .PW(PW), .NW(NW)
    ) u_need (
        .counts     (q_count),
        .bv         (state_q.valid),
        .bq         (qsel_flat),
        .self_valid (self_valid),
        .self_q     (self_q),
        .need       (need),
        .elig       (need_elig)
    );

    tqb_argmax #(.N(NUM_Q), .W(CNT_W), .IW(QW)) u_full_max (
        .vals  (q_count),
        .elig  (cnt_elig),
        .found (full_found),
        .idx   (full_idx)
    );

    tqb_argmax #(.N(NUM_Q), .W(NW), .IW(QW)) u_need_max (
        .vals  (need),
        .elig  (need_elig),
        .found (need_found),
        .idx   (need_idx)
    );

    tqb_lookup #(.NUM_PROC(NUM_PROC), .QW(QW), .PW(PW)) u_lookup (
        .bv   (state_q.valid),
        .bq   (qsel_flat),
        .key  (lookup_q),
        .hit  (lookup_hit),
        .proc (lookup_proc)
    );

    always_comb begin
        logic          got;
        logic [QW-1:0] tgt;
        state_d = state_q;
        got     = (pol == POL_NEEDBASE) ? need_found : full_found;
        tgt     = (pol == POL_NEEDBASE) ? need_idx   : full_idx;
        if (pick_found) begin
            state_d.valid[pick_idx] = got;
            state_d.qsel[pick_idx]  = got ? tgt : '0;
            state_d.ptr = (int'(pick_idx) == NUM_PROC - 1) ? '0 : pick_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bind_valid = state_q.valid;
    assign bind_q     = qsel_flat;
endmodule

// File: rtl/treelet_binder_chk.sv
module treelet_binder_chk #(
    parameter int NUM_PROC = 16,
    parameter int NUM_Q    = 8,
    parameter int CNT_W    = 8,
    parameter int QW       = 3,
    parameter int PW       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    policy,
    input  logic [NUM_Q*CNT_W-1:0]  q_count,
    input  logic [NUM_PROC-1:0]     proc_empty,
    input  logic [QW-1:0]           lookup_q,
    input  logic [NUM_PROC-1:0]     bind_valid,
    input  logic [NUM_PROC*QW-1:0]  bind_q,
    input  logic                    lookup_hit,
    input  logic [PW-1:0]           lookup_proc
);
    logic [NUM_PROC-1:0]     prev_valid;
    logic [NUM_PROC*QW-1:0]  prev_q;
    logic [NUM_PROC-1:0]     prev_empty;
    logic [NUM_Q*CNT_W-1:0]  prev_cnt;
    logic                    prev_pol;
    logic [NUM_PROC-1:0]     chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_valid <= '0;
            prev_q     <= '0;
            prev_empty <= '0;
            prev_cnt   <= '0;
            prev_pol   <= 1'b0;
        end else begin
            prev_valid <= bind_valid;
            prev_q     <= bind_q;
            prev_empty <= proc_empty;
            prev_cnt   <= q_count;
            prev_pol   <= policy;
        end
    end

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_p
        logic [QW-1:0]    cur_q;
        logic [CNT_W-1:0] tgt_cnt;
        assign cur_q   = bind_q[p*QW +: QW];
        assign tgt_cnt = prev_cnt[cur_q*CNT_W +: CNT_W];
        assign chg[p]  = (prev_valid[p] != bind_valid[p]) || (prev_q[p*QW +: QW] != cur_q);

        AST_HOLD_UNLESS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            !prev_empty[p] |-> !chg[p]); // R2
        AST_TARGET_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            (chg[p] && bind_valid[p]) |-> (tgt_cnt != '0)); // R4
        AST_IDLE_ONLY_WHEN_DRY: assert property (@(posedge clk) disable iff (!rst_n)
            (chg[p] && !bind_valid[p] && !prev_pol) |-> (prev_cnt == '0)); // R6
    end

    AST_ONE_REBIND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1); // R3

    AST_LOOKUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_hit |-> (bind_valid[lookup_proc] && bind_q[lookup_proc*QW +: QW] == lookup_q)); // R7
endmodule

bind treelet_binder treelet_binder_chk #(
    .NUM_PROC(NUM_PROC), .NUM_Q(NUM_Q), .CNT_W(CNT_W), .QW(QW), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .policy(policy), .q_count(q_count),
    .proc_empty(proc_empty), .lookup_q(lookup_q), .bind_valid(bind_valid),
    .bind_q(bind_q), .lookup_hit(lookup_hit), .lookup_proc(lookup_proc)
);

// File: tb/treelet_binder_tb.sv
`timescale 1ns/1ps
module treelet_binder_tb;
    localparam int NP = 16;
    localparam int NQ = 8;
    localparam int CW = 8;
    localparam int QT = 4;
    localparam int QW = 3;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic policy = 1'b0;
    logic [NQ*CW-1:0] q_count = '0;
    logic [NP-1:0] proc_empty = '0;
    logic [QW-1:0] lookup_q = '0;
    logic [NP-1:0] bind_valid;
    logic [NP*QW-1:0] bind_q;
    logic lookup_hit;
    logic [PW-1:0] lookup_proc;

    always #4 clk = ~clk;

    treelet_binder #(.NUM_PROC(NP), .NUM_Q(NQ), .CNT_W(CW), .QUOTA(QT)) u_dut (
        .clk(clk), .rst_n(rst_n), .policy(policy), .q_count(q_count),
        .proc_empty(proc_empty), .lookup_q(lookup_q), .bind_valid(bind_valid),
        .bind_q(bind_q), .lookup_hit(lookup_hit), .lookup_proc(lookup_proc)
    );

    int n_tests = 0;
    int n_fail = 0;
    int m_valid [NP];
    int m_q [NP];
    int m_ptr = 0;
    string cur_tag = "R8";
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cnt(input int q);
        return int'(q_count[q*CW +: CW]);
    endfunction

    task automatic set_cnt(input int q, input int v);
        q_count[q*CW +: CW] = CW'(v);
    endtask

    function automatic int unsigned rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic model_step();
        int p, best, bq, got;
        p = -1;
        for (int i = 0; i < NP; i++) begin
            int j;
            j = (m_ptr + i) % NP;
            if (p < 0 && proc_empty[j]) p = j;
        end
        if (p < 0) return;
        got = 0; best = 0; bq = 0;
        for (int q = 0; q < NQ; q++) begin
            int v;
            if (policy == 1'b0) begin
                v = cnt(q);
            end else begin
                int b;
                b = 0;
                for (int k = 0; k < NP; k++)
                    if (k != p && m_valid[k] != 0 && m_q[k] == q) b++;
                v = (cnt(q) + QT - 1) / QT - b;
            end
            if (v > 0 && (got == 0 || v > best)) begin
                got = 1; best = v; bq = q;
            end
        end
        m_valid[p] = got;
        m_q[p] = got != 0 ? bq : 0;
        m_ptr = (p + 1) % NP;
    endtask

    task automatic compare_all();
        logic [NP-1:0] ev;
        logic [NP*QW-1:0] eq;
        int eh, ep;
        for (int p = 0; p < NP; p++) begin
            ev[p] = m_valid[p] != 0;
            eq[p*QW +: QW] = QW'(m_q[p]);
        end
        chk({cur_tag, " bindings valid"}, int'(bind_valid), int'(ev));
        chk({cur_tag, " bindings queue"}, int'(bind_q), int'(eq));
        eh = 0; ep = 0;
        for (int p = NP - 1; p >= 0; p--)
            if (m_valid[p] != 0 && m_q[p] == int'(lookup_q)) begin eh = 1; ep = p; end
        chk("R7 lookup hit", int'(lookup_hit), eh);
        chk("R7 lookup proc", int'(lookup_proc), ep);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    function automatic int bq_of(input int p);
        return int'(bind_q[p*QW +: QW]);
    endfunction

    initial begin
        for (int p = 0; p < NP; p++) begin m_valid[p] = 0; m_q[p] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid after reset", int'(bind_valid), 0);
        chk("R1 queue after reset", int'(bind_q), 0);
        chk("R1 lookup after reset", int'(lookup_hit), 0);
        rst_n = 1'b1;
        tick();

        // R4 / R9: fullest policy, tie between queues 1 and 2
        set_cnt(0, 5); set_cnt(1, 9); set_cnt(2, 9); set_cnt(3, 2);
        proc_empty = 16'h000F;
        cur_tag = "R4";
        repeat (4) tick();
        proc_empty = '0;
        for (int p = 0; p < 4; p++) begin
            chk("R4 fullest tie to lowest", bq_of(p), 1);
            chk("R9 shared queue valid", int'(bind_valid[p]), 1);
        end

        // R2: no empty flag, counts move, bindings hold
        cur_tag = "R2";
        set_cnt(4, 200); set_cnt(1, 0);
        repeat (3) tick();
        chk("R2 binding held", bq_of(0), 1);
        set_cnt(1, 9); set_cnt(4, 0);

        // R7: lookup sweep
        for (int q = 0; q < NQ; q++) begin
            lookup_q = QW'(q);
            tick();
        end

        // R5: need-based policy after the pile-up on queue 1
        policy = 1'b1;
        set_cnt(0, 0); set_cnt(3, 0); set_cnt(5, 20);
        proc_empty = 16'h03F0;
        cur_tag = "R5";
        repeat (6) tick();
        proc_empty = '0;
        chk("R5 largest need", bq_of(4), 5);
        chk("R5 tie to lowest", bq_of(6), 2);
        lookup_q = 3'd5;
        tick();
        chk("R7 lowest serving proc", int'(lookup_proc), 4);

        // R6: nothing left, processor 0 parks idle
        policy = 1'b0;
        q_count = '0;
        proc_empty = 16'h0001;
        cur_tag = "R6";
        tick();
        proc_empty = '0;
        chk("R6 idle when dry", int'(bind_valid[0]), 0);
        tick();

        // R3: all drained at once, one rebind per clock in rotation
        set_cnt(7, 50);
        proc_empty = '1;
        cur_tag = "R3";
        tick();
        chk("R3 rotation picks proc after last", bq_of(1), 7);
        chk("R3 single rebind", int'(bind_valid[2]), 1);
        repeat (20) tick();
        proc_empty = '0;

        // R8: pseudo-random traffic, model compared every clock
        cur_tag = "R8";
        for (int c = 0; c < 2000; c++) begin
            if (rnd() % 16 == 0) policy = ~policy;
            for (int q = 0; q < NQ; q++)
                if (rnd() % 4 == 0) set_cnt(q, (rnd() % 3 == 0) ? 0 : int'(rnd() % 256));
            for (int p = 0; p < NP; p++) proc_empty[p] = (rnd() % 5 == 0);
            lookup_q = QW'(rnd());
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule